// File: doc/BRIEF.md
# External Data Bus Cycle Sequencer

This block runs one data-memory transfer at a time on a multiplexed address/data bus. The core hands it a 16-bit address, a direction and a write byte over a valid/ready request channel. The block decides whether the address falls inside a small internal RAM window or belongs on the external bus. It then plays out a fixed-length cycle counted in 4-clock machine cycles and reports completion with a one-clock done pulse that carries the read byte.

External cycles open with a two-clock address-latch pulse. The low address byte is on the shared lines and the high byte is on its own lines. A settling gap follows, then a read or write strobe, then a hold gap. A 3-bit stretch setting makes the strobe wider and the whole cycle longer. The setting is held in a register that resets to 1 and can be written at any time. Each access takes a copy of it when it is accepted. Internal window accesses always run at the shortest length, drive no strobes and ignore the stretch. An option keeps the latch pulse quiet for internal accesses.

Back-pressure rules: `req_ready` is high only while no access is in flight. A request transfers on a clock where `req_valid` and `req_ready` are both high, and the address, direction and write data are taken at that edge. The response side has no back-pressure. `rsp_valid` is a single-clock pulse that the core must take.

Top module: `xdm_seq`

## Requirements
- R1: After reset `req_ready` is 1, `bus_ale` is 0, both strobes are high (inactive), `rsp_valid` is 0, and the stretch register holds 1.
- R2: An external access with stretch s lasts 4*(s+2) clocks, counted from the first clock after the accepting edge. `rsp_valid` is high for exactly the last of them.
- R3: The strobe (`bus_rd_n` for a read, `bus_wr_n` for a write) is low for one contiguous run of 2 clocks when s=0 and 4*s clocks when s>0. The two strobes are never low together.
- R4: On external accesses, `bus_ale` is high in clocks 0 and 1 of the access. The gap between ALE falling and the strobe starting is 2 clocks, plus 1 when s>0. The gap from the strobe ending to the end of the access is 2 clocks, plus 1 when s>0.
- R5: With `cfg_win_en`=1, addresses 0x0000 to 0x03FF use the internal RAM. Such an access lasts 8 clocks whatever the stretch, drives no strobe, stores a write, and returns the stored byte on a later read.
- R6: With `cfg_win_en`=0, every address goes to the external bus, including 0x0000 to 0x03FF.
- R7: With `cfg_win_en`=1, addresses 0x0400 and above go to the external bus.
- R8: `bus_ale` pulses for 2 clocks on every external access and on internal accesses while `cfg_ale_quiet`=0. With `cfg_ale_quiet`=1 it stays low for internal accesses and still pulses for external ones.
- R9: The stretch value is taken when the access is accepted. A write to the stretch register during an access does not change that access, and it applies to the next one.
- R10: An external read returns on `rsp_rdata` the byte present on `bus_ad_in` in the last clock of the read strobe.
- R11: During an external access `bus_a_hi` carries address bits 15:8. While ALE is high, `bus_ad_out` carries bits 7:0 with `bus_ad_oe`=1. On a write, `bus_ad_out` carries the write byte with `bus_ad_oe`=1 throughout the strobe.
- R12: `req_ready` stays low from the accepting edge until the access ends, and returns high in the clock after the `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can transfer |
| req_addr | input | 16 | Data-memory address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-clock done pulse |
| rsp_rdata | output | 8 | Read byte, valid with rsp_valid |
| cfg_stretch_we | input | 1 | Load strobe for the stretch register |
| cfg_stretch_wd | input | 3 | New stretch value |
| cfg_win_en | input | 1 | Enable the internal RAM window |
| cfg_ale_quiet | input | 1 | Keep ALE low on internal accesses |
| bus_ale | output | 1 | Address latch enable |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_a_hi | output | 8 | High address byte |
| bus_ad_out | output | 8 | Multiplexed address/data out |
| bus_ad_oe | output | 1 | Output enable for bus_ad_out |
| bus_ad_in | input | 8 | Multiplexed data in |

## Verification
The bench builds the block with its default parameters: a 4-clock machine cycle, a 3-bit stretch field that resets to 1, and a 10-bit internal window. With these values every stretch code from 0 to 7 can be reached, so the shortest external cycle (8 clocks) and the longest (36 clocks) are both measured clock by clock. They are compared with internal accesses that stay at 8 clocks under a large stretch. The 0x03FF/0x0400 window edge and the window-disabled case can both be hit with real addresses.

// File: rtl/xdm_pkg.sv
package xdm_pkg;

  // first clock index of the strobe within an access
  function automatic int unsigned stb_first(input int unsigned s, input int unsigned mc);
    return mc + ((s != 0) ? 1 : 0);
  endfunction

  // strobe width in clocks
  function automatic int unsigned stb_len(input int unsigned s, input int unsigned mc);
    return (s == 0) ? (mc / 2) : (mc * s);
  endfunction

  // whole access length in clocks
  function automatic int unsigned acc_len(input int unsigned s, input int unsigned mc);
    return mc * (s + 2);
  endfunction

endpackage

// File: rtl/xdm_win_dec.sv
module xdm_win_dec #(
  parameter int ADDR_W  = 16,
  parameter int IRAM_AW = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              win_en,
  output logic              is_int
);
  localparam int HI_W = ADDR_W - IRAM_AW;

  always_comb begin
    is_int = win_en && (addr[ADDR_W-1:IRAM_AW] == {HI_W{1'b0}});
  end
endmodule

// File: rtl/xdm_iram.sv
module xdm_iram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/xdm_phase_gen.sv
module xdm_phase_gen
  import xdm_pkg::*;
#(
  parameter int MC = 4,
  parameter int SW = 3,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [SW-1:0] stretch,
  output logic          busy,
  output logic          ale_win,
  output logic          stb_win,
  output logic          data_win,
  output logic          cap,
  output logic          last
);
  localparam int ALE_LEN = MC / 2;

  logic          busy_q;
  logic [CW-1:0] cnt_q, lo_q, hi_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      last_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      lo_q   <= CW'(stb_first(int'(stretch), MC));
      hi_q   <= CW'(stb_first(int'(stretch), MC) + stb_len(int'(stretch), MC) - 1);
      last_q <= CW'(acc_len(int'(stretch), MC) - 1);
    end else if (busy_q) begin
      if (cnt_q == last_q) busy_q <= 1'b0;
      else                 cnt_q  <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    busy     = busy_q;
    ale_win  = busy_q && (cnt_q < CW'(ALE_LEN));
    stb_win  = busy_q && (cnt_q >= lo_q) && (cnt_q <= hi_q);
    data_win = busy_q && (cnt_q >= CW'(ALE_LEN));
    cap      = busy_q && (cnt_q == hi_q);
    last     = busy_q && (cnt_q == last_q);
  end

  // R2: the final count closes the access
  p_last_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);

  // R9: bounds chosen at start hold for the whole access
  p_bounds_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> ($stable(last_q) && $stable(hi_q)));

  // R4: address phase and strobe never overlap
  p_ale_before_stb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stb_win |-> !ale_win);
endmodule

// File: rtl/xdm_seq.sv
module xdm_seq #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int IRAM_AW     = 10,
  parameter int MC          = 4,
  parameter int SW          = 3,
  parameter int STRETCH_RST = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              cfg_stretch_we,
  input  logic [SW-1:0]     cfg_stretch_wd,
  input  logic              cfg_win_en,
  input  logic              cfg_ale_quiet,
  output logic              bus_ale,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [ADDR_W-DATA_W-1:0] bus_a_hi,
  output logic [DATA_W-1:0] bus_ad_out,
  output logic              bus_ad_oe,
  input  logic [DATA_W-1:0] bus_ad_in
);
  localparam int MAX_LEN = MC * ((1 << SW) + 1);
  localparam int CW      = $clog2(MAX_LEN + 1);
  localparam int HI_W    = ADDR_W - DATA_W;

  logic              start, is_int, busy, ale_win, stb_win, data_win, cap, last;
  logic [SW-1:0]     stretch_q, eff_s;
  logic              int_q, write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, iram_rd;
  logic              ext_act;

  assign req_ready = !busy;
  assign start     = req_valid && req_ready;

  xdm_win_dec #(.ADDR_W(ADDR_W), .IRAM_AW(IRAM_AW)) u_dec (
    .addr(req_addr), .win_en(cfg_win_en), .is_int(is_int)
  );

  assign eff_s = is_int ? '0 : stretch_q;

  xdm_phase_gen #(.MC(MC), .SW(SW), .CW(CW)) u_phase (
    .clk(clk), .rst_n(rst_n), .start(start), .stretch(eff_s),
    .busy(busy), .ale_win(ale_win), .stb_win(stb_win),
    .data_win(data_win), .cap(cap), .last(last)
  );

  xdm_iram #(.AW(IRAM_AW), .DW(DATA_W)) u_iram (
    .clk(clk), .we(cap && int_q && write_q),
    .addr(addr_q[IRAM_AW-1:0]), .wdata(wdata_q), .rdata(iram_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stretch_q <= SW'(STRETCH_RST);
      int_q     <= 1'b0;
      write_q   <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
    end else begin
      if (cfg_stretch_we) stretch_q <= cfg_stretch_wd;
      if (start) begin
        int_q   <= is_int;
        write_q <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (cap && !write_q) rdata_q <= int_q ? iram_rd : bus_ad_in;
    end
  end

  assign ext_act    = busy && !int_q;
  assign rsp_valid  = last;
  assign rsp_rdata  = rdata_q;
  assign bus_ale    = ale_win && (!int_q || !cfg_ale_quiet);
  assign bus_rd_n   = !(ext_act && !write_q && stb_win);
  assign bus_wr_n   = !(ext_act && write_q && stb_win);
  assign bus_a_hi   = ext_act ? addr_q[ADDR_W-1:DATA_W] : {HI_W{1'b0}};
  assign bus_ad_out = ale_win ? addr_q[DATA_W-1:0] : wdata_q;
  assign bus_ad_oe  = ext_act && (ale_win || (write_q && data_win));

  // R3: strobes are mutually exclusive
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n));

  // R5: internal accesses never touch the strobes
  p_int_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && int_q) |-> (bus_rd_n && bus_wr_n));

  // R2: done is a single clock
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R12: ready returns right after done
  p_ready_after_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);

  // R8: latch pulse is never under a strobe
  p_ale_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (bus_rd_n && bus_wr_n));
endmodule

// File: tb/xdm_seq_tb.sv
module xdm_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready, rsp_valid;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, rsp_rdata;
  logic        cfg_stretch_we = 1'b0;
  logic [2:0]  cfg_stretch_wd = '0;
  logic        cfg_win_en = 1'b0, cfg_ale_quiet = 1'b0;
  logic        bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe;
  logic [7:0]  bus_a_hi, bus_ad_out, bus_ad_in;
  logic [15:0] lat_addr = '0;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  xdm_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cfg_stretch_we(cfg_stretch_we), .cfg_stretch_wd(cfg_stretch_wd),
    .cfg_win_en(cfg_win_en), .cfg_ale_quiet(cfg_ale_quiet),
    .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_a_hi(bus_a_hi), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
    .bus_ad_in(bus_ad_in)
  );

  // external memory model: latches address on ALE, answers a hash while read strobe low
  always @(posedge clk) if (bus_ale) lat_addr <= {bus_a_hi, bus_ad_out};
  always_comb bus_ad_in = !bus_rd_n ? (lat_addr[15:8] ^ lat_addr[7:0] ^ 8'h5A) : 8'hEE;

  function automatic logic [7:0] ext_val(input logic [15:0] a);
    return a[15:8] ^ a[7:0] ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_stretch(input int s);
    @(negedge clk);
    cfg_stretch_we = 1'b1; cfg_stretch_wd = 3'(s);
    @(negedge clk);
    cfg_stretch_we = 1'b0;
  endtask

  // one access, measured clock by clock at negedges
  task automatic do_acc(input string tag, input logic [15:0] a, input logic wr,
                        input logic [7:0] wd, input bit ext, input int s,
                        input int exp_ale, input logic [7:0] exp_rd, input int mid_s);
    int n = 0, ale_n = 0, ale_last = -1, stb_n = 0, stb_first = -1, stb_last = -1;
    int done_n = 0, bad_bus = 0, ready_hi = 0, other_stb = 0;
    int exp_len, exp_first, exp_slen;
    logic [7:0] got_rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (done_n == 0 && n < 60) begin
      if (n == 2 && mid_s >= 0) begin cfg_stretch_we = 1'b1; cfg_stretch_wd = 3'(mid_s); end
      if (n == 3) cfg_stretch_we = 1'b0;
      if (req_ready) ready_hi++;
      if (bus_ale) begin
        ale_n++; ale_last = n;
        if (ext && (!bus_ad_oe || bus_ad_out != a[7:0])) bad_bus++;
      end
      if ((wr ? bus_wr_n : bus_rd_n) == 1'b0) begin
        stb_n++; if (stb_first < 0) stb_first = n; stb_last = n;
        if (wr && (!bus_ad_oe || bus_ad_out != wd)) bad_bus++;
      end
      if ((wr ? bus_rd_n : bus_wr_n) == 1'b0) other_stb++;
      if (ext && bus_a_hi != a[15:8]) bad_bus++;
      if (rsp_valid) begin done_n = n + 1; got_rd = rsp_rdata; end
      n++;
      @(negedge clk);
    end
    cfg_stretch_we = 1'b0;
    exp_len = ext ? 4 * (s + 2) : 8;
    chk({tag, " R2 length"}, done_n, exp_len);
    chk({tag, " R12 ready low while busy"}, ready_hi, 0);
    chk({tag, " R12 ready back after done"}, int'(req_ready), 1);
    chk({tag, " R8 ale clocks"}, ale_n, exp_ale);
    chk({tag, " R3 other strobe idle"}, other_stb, 0);
    if (ext) begin
      exp_slen = (s == 0) ? 2 : 4 * s;
      exp_first = 4 + ((s != 0) ? 1 : 0);
      chk({tag, " R3 strobe width"}, stb_n, exp_slen);
      chk({tag, " R3 strobe contiguous"}, stb_last - stb_first + 1, exp_slen);
      chk({tag, " R4 ale position"}, ale_last, 1);
      chk({tag, " R4 setup"}, stb_first - 2, 2 + ((s != 0) ? 1 : 0));
      chk({tag, " R4 hold"}, (done_n - 1) - stb_last, 2 + ((s != 0) ? 1 : 0));
      chk({tag, " R11 bus address/data"}, bad_bus, 0);
    end else begin
      chk({tag, " R5 no strobe internal"}, stb_n, 0);
    end
    if (!wr) chk({tag, " R10 read data"}, int'(got_rd), int'(exp_rd));
  endtask

  task automatic t_reset;
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 ale", int'(bus_ale), 0);
    chk("R1 rd_n", int'(bus_rd_n), 1);
    chk("R1 wr_n", int'(bus_wr_n), 1);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
  endtask

  task automatic t_default_stretch;  // R1: reset stretch is 1
    do_acc("R1 default", 16'h1234, 1'b0, 8'h00, 1, 1, 2, ext_val(16'h1234), -1);
  endtask

  task automatic t_stretch_sweep;  // R2 R3 R4 R11 over several codes
    set_stretch(0);
    do_acc("s0 write", 16'h8001, 1'b1, 8'hC3, 1, 0, 2, 8'h00, -1);
    set_stretch(7);
    do_acc("s7 read", 16'hFFFF, 1'b0, 8'h00, 1, 7, 2, ext_val(16'hFFFF), -1);
    set_stretch(3);
    do_acc("s3 write", 16'h4A5B, 1'b1, 8'h3C, 1, 3, 2, 8'h00, -1);
  endtask

  task automatic t_window_off;  // R6
    set_stretch(2);
    cfg_win_en = 1'b0;
    do_acc("R6 win off", 16'h0123, 1'b0, 8'h00, 1, 2, 2, ext_val(16'h0123), -1);
  endtask

  task automatic t_internal;  // R5 R8
    set_stretch(5);
    cfg_win_en = 1'b1; cfg_ale_quiet = 1'b0;
    do_acc("R5 int write", 16'h0123, 1'b1, 8'hA7, 0, 5, 2, 8'h00, -1);
    cfg_ale_quiet = 1'b1;
    do_acc("R8 quiet int read", 16'h0123, 1'b0, 8'h00, 0, 5, 0, 8'hA7, -1);
    do_acc("R5 edge 03FF write", 16'h03FF, 1'b1, 8'h19, 0, 5, 0, 8'h00, -1);
    do_acc("R5 edge 03FF read", 16'h03FF, 1'b0, 8'h00, 0, 5, 0, 8'h19, -1);
  endtask

  task automatic t_window_edge;  // R7 R8
    set_stretch(1);
    cfg_win_en = 1'b1; cfg_ale_quiet = 1'b1;
    do_acc("R7 addr 0400", 16'h0400, 1'b0, 8'h00, 1, 1, 2, ext_val(16'h0400), -1);
    cfg_ale_quiet = 1'b0;
  endtask

  task automatic t_mid_change;  // R9
    set_stretch(2);
    do_acc("R9 old stretch", 16'h2000, 1'b0, 8'h00, 1, 2, 2, ext_val(16'h2000), 6);
    do_acc("R9 new stretch", 16'h3000, 1'b0, 8'h00, 1, 6, 2, ext_val(16'h3000), -1);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_stretch();
    t_stretch_sweep();
    t_window_off();
    t_internal();
    t_window_edge();
    t_mid_change();
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule